// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer: a presettable down counter with a count-enable tick, a GATE input and one output. A control write selects one of six behaviours (terminal-count flag, retriggerable one-shot, rate generator, square wave, software-started strobe and gate-started strobe). It also selects plain binary or four-digit decimal (BCD) counting. A separate count write supplies the initial value as a parallel word.

The counter advances only in clock cycles where `tick` is high. The GATE level is sampled on ticks, and a rising edge is a tick where GATE is high after being low at the previous tick. Bus decoding, byte sequencing and read-back of the live count belong to the surrounding logic. The output waveform is the only result of the block.

Top module: `ict_channel`

## Requirements
- R1: After reset the output is high and stays high under ticks and GATE activity until a control word and a count are written.
- R2: Mode 0 (`mode_in`=0): a control write drives the output low. A count write of N keeps it low, and it goes high after N enabled ticks and stays high. Ticks with GATE low do not count. A new count write drives the output low again.
- R3: Mode 1: after a GATE rising edge the output is low for N ticks, counting the edge tick. A further rising edge during the pulse reloads N and lengthens the pulse.
- R4: Mode 2: with GATE high the output is low exactly at ticks k where k mod N = N-1, with k counted from the count write, giving period N (N >= 2).
- R5: Mode 3: with GATE high the output is high for ceil(N/2) ticks and low for floor(N/2) ticks of every N-tick period, starting high.
- R6: Modes 2 and 3: GATE low stops counting and forces the output high at the next clock edge, with or without a tick. A GATE rising edge reloads N with the output high.
- R7: Mode 4: after a count write the output goes low once, for one tick, after N-1 enabled ticks. GATE low pauses counting and leaves the output unchanged. A new count write restarts the sequence.
- R8: Mode 5: a GATE rising edge loads N, counting the edge tick. The output is low at the N-th tick after it and high otherwise. A later rising edge reloads N.
- R9: With `bcd_in`=1 the count word holds four decimal digits, with the least significant digit in bits 3:0, and counts down in decimal.
- R10: A count of 0 acts as 65536 in binary and 10000 in decimal.
- R11: GATE is looked at only in tick cycles. Without a tick the count and output hold (apart from the R6 force), and a GATE pulse between ticks is not an edge.
- R12: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| gate | input | 1 | Gate level |
| ctrl_wr | input | 1 | Control word write strobe |
| mode_in | input | 3 | Operating mode code |
| bcd_in | input | 1 | 1 selects decimal counting |
| count_wr | input | 1 | Initial count write strobe |
| count_in | input | W (16) | Initial count value |
| out | output | 1 | Channel output |

## Verification
The assertions assume that the two write strobes never fall in the same cycle and that a count written in decimal mode has every digit at 9 or below. They also assume counts of at least 2 in the modes that strobe or toggle. Under those conditions the decimal step never leaves valid digits, and every one-tick strobe in modes 2 and 5 ends at the next tick. The stimulus issues each write as a single pulse in a cycle without a tick. It changes GATE half a clock away from the active edge and uses only legal decimal words and counts of two or more in modes 2 to 5.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    ICT_M0 = 3'd0,  // flag on terminal count
    ICT_M1 = 3'd1,  // retriggerable one-shot
    ICT_M2 = 3'd2,  // rate generator
    ICT_M3 = 3'd3,  // square wave
    ICT_M4 = 3'd4,  // software-started strobe
    ICT_M5 = 3'd5   // gate-started strobe
  } ict_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic ict_mode_e ict_decode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return ict_mode_e'({1'b0, code[1:0]});
    return ict_mode_e'(code);
  endfunction

endpackage

// File: rtl/ict_gate_edge.sv
module ict_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gate,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (tick)  prev_q <= gate;
  end

  assign rise_o = tick & gate & ~prev_q;

endmodule

// File: rtl/ict_down_step.sv
module ict_down_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] init_i,
  input  logic         bcd_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] thr_o,
  output logic         at_one_o,
  output logic         nxt_one_o,
  output logic         nxt_zero_o
);
  localparam int DIG = W / 4;

  function automatic logic [W-1:0] dec_bcd(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic         borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIG; i++) begin
      if (borrow) begin
        if (r[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // floor(N/2) in decimal digits; 0 stands for 10^DIG
  function automatic logic [W-1:0] half_bcd(input logic [W-1:0] v);
    logic [W-1:0] r;
    int rem;
    int val;
    r = '0;
    rem = 0;
    if (v == '0) r[(DIG-1)*4 +: 4] = 4'd5;
    else begin
      for (int i = DIG - 1; i >= 0; i--) begin
        val = rem * 10 + int'(v[i*4 +: 4]);
        r[i*4 +: 4] = 4'(val / 2);
        rem = val % 2;
      end
    end
    return r;
  endfunction

  // floor(N/2) in binary; 0 stands for 2^W
  function automatic logic [W-1:0] half_bin(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v >> 1;
    if (v == '0) r[W-1] = 1'b1;
    return r;
  endfunction

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIG; i++)
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  assign nxt_o      = bcd_i ? dec_bcd(cnt_i) : (cnt_i - W'(1));
  assign thr_o      = bcd_i ? half_bcd(init_i) : half_bin(init_i);
  assign at_one_o   = (cnt_i == W'(1));
  assign nxt_one_o  = (nxt_o == W'(1));
  assign nxt_zero_o = (nxt_o == '0);

  // R9: a legal decimal count steps to a legal decimal count
  always_comb begin
    p_bcd_step_r9: assert (!(bcd_i && digits_ok(cnt_i)) || digits_ok(nxt_o));
  end

endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic         ctrl_wr,
  input  logic [2:0]   mode_in,
  input  logic         bcd_in,
  input  logic         count_wr,
  input  logic [W-1:0] count_in,
  output logic         out
);
  ict_mode_e   mode_q;
  ict_mode_e   mode_new;
  logic        bcd_q;
  logic        run_q;
  logic        loaded_q;
  logic        out_q;
  logic [W-1:0] init_q;
  logic [W-1:0] cnt_q;

  // named internal events
  logic         gate_rise;
  logic         gate_free;
  logic         cnt_tick;
  logic [W-1:0] nxt;
  logic [W-1:0] thr;
  logic         at_one;
  logic         nxt_one;
  logic         nxt_zero;

  ict_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .gate   (gate),
    .rise_o (gate_rise)
  );

  ict_down_step #(.W(W)) u_step (
    .cnt_i      (cnt_q),
    .init_i     (init_q),
    .bcd_i      (bcd_q),
    .nxt_o      (nxt),
    .thr_o      (thr),
    .at_one_o   (at_one),
    .nxt_one_o  (nxt_one),
    .nxt_zero_o (nxt_zero)
  );

  assign mode_new  = ict_decode(mode_in);
  assign gate_free = (mode_q == ICT_M1) || (mode_q == ICT_M5);
  assign cnt_tick  = tick & run_q & (gate_free | gate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= ICT_M0;
      bcd_q    <= 1'b0;
      init_q   <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      out_q    <= 1'b1;
    end else if (ctrl_wr) begin
      mode_q   <= mode_new;
      bcd_q    <= bcd_in;
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      out_q    <= (mode_new != ICT_M0);
    end else if (count_wr) begin
      init_q   <= count_in;
      loaded_q <= 1'b1;
      if (!gate_free) begin
        cnt_q <= count_in;
        run_q <= 1'b1;
        out_q <= (mode_q != ICT_M0);
      end
    end else begin
      case (mode_q)
        ICT_M0: begin
          if (cnt_tick) begin
            cnt_q <= nxt;
            if (nxt_zero) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
        end
        ICT_M1, ICT_M5: begin
          if (gate_rise && loaded_q) begin
            cnt_q <= init_q;
            run_q <= 1'b1;
            out_q <= (mode_q != ICT_M1);
          end else if (cnt_tick) begin
            if (at_one) begin
              run_q <= 1'b0;
              out_q <= 1'b1;
            end else begin
              cnt_q <= nxt;
              out_q <= (mode_q == ICT_M1) ? 1'b0 : !nxt_one;
            end
          end
        end
        ICT_M2, ICT_M3: begin
          if (!gate) begin
            out_q <= 1'b1;
          end else if (gate_rise && run_q) begin
            cnt_q <= init_q;
            out_q <= 1'b1;
          end else if (cnt_tick) begin
            if (at_one) begin
              cnt_q <= init_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= nxt;
              out_q <= (mode_q == ICT_M2) ? !nxt_one : (nxt > thr);
            end
          end
        end
        ICT_M4: begin
          if (cnt_tick) begin
            if (at_one) begin
              run_q <= 1'b0;
              out_q <= 1'b1;
            end else begin
              cnt_q <= nxt;
              out_q <= !nxt_one;
            end
          end
        end
        default: out_q <= 1'b1;
      endcase
    end
  end

  assign out = out_q;

  // R2: arming mode 0 with a count pulls the output low
  p_m0_arm_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ICT_M0 && count_wr && !ctrl_wr) |=> !out_q);

  // R3: an accepted trigger starts the one-shot pulse
  p_one_shot_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ICT_M1 && gate_rise && loaded_q && !ctrl_wr && !count_wr) |=> !out_q);

  // R4 / R8: a low strobe lasts a single tick
  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == ICT_M2 || mode_q == ICT_M5) && !out_q && tick && !ctrl_wr && !count_wr)
    |=> out_q);

  // R6: gate low forces the output high in modes 2 and 3
  p_gate_force_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == ICT_M2 || mode_q == ICT_M3) && !gate && !ctrl_wr && !count_wr) |=> out_q);

  // R7: gate low freezes mode 4 without touching the output
  p_m4_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ICT_M4 && !gate && !ctrl_wr && !count_wr) |=> $stable(out_q));

  // R11: no tick, no write, gate high: nothing moves
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr && !count_wr && gate) |=> ($stable(out_q) && $stable(cnt_q)));

endmodule

// File: tb/sim_ict_channel.sv
module sim_ict_channel;
  localparam int W = 16;
  localparam int WATCHDOG = 190000;
  localparam int NVEC = 13;
  // {mode code, bcd, count (decimal value), ticks to watch}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 16'd7,  16'd12},
    {4'd0, 4'd1, 16'd23, 16'd30},
    {4'd1, 4'd0, 16'd4,  16'd10},
    {4'd2, 4'd0, 16'd5,  16'd16},
    {4'd2, 4'd1, 16'd12, 16'd30},
    {4'd3, 4'd0, 16'd6,  16'd20},
    {4'd3, 4'd0, 16'd7,  16'd22},
    {4'd3, 4'd1, 16'd11, 16'd25},
    {4'd4, 4'd0, 16'd6,  16'd10},
    {4'd5, 4'd0, 16'd3,  16'd8},
    {4'd5, 4'd1, 16'd10, 16'd14},
    {4'd6, 4'd0, 16'd4,  16'd10},
    {4'd7, 4'd0, 16'd4,  16'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic gate = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [2:0] mode_in = 3'd0;
  logic bcd_in = 1'b0;
  logic count_wr = 1'b0;
  logic [W-1:0] count_in = '0;
  logic out_w;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ict_channel #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
    .ctrl_wr(ctrl_wr), .mode_in(mode_in), .bcd_in(bcd_in),
    .count_wr(count_wr), .count_in(count_in), .out(out_w)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input logic exp, input string req, input string what);
    n_chk++;
    if (out_w !== exp) begin
      n_bad++;
      $display("FAIL %s %s: out=%b expected %b", req, what, out_w, exp);
    end
  endtask

  task automatic step();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctrl(input logic [2:0] m, input logic b);
    ctrl_wr = 1'b1; mode_in = m; bcd_in = b;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    count_wr = 1'b1; count_in = v;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  // trig=1: gate left low so that the first tick after setup is a rising edge
  task automatic setup(input logic [2:0] m, input logic b, input logic [W-1:0] v, input bit trig);
    gate = !trig;
    step();
    wr_ctrl(m, b);
    wr_cnt(v);
    gate = 1'b1;
  endtask

  function automatic logic [W-1:0] to_bcd(input int n);
    logic [W-1:0] r;
    int x;
    x = n;
    r = '0;
    for (int d = 0; d < W / 4; d++) begin
      r[d*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  // expected output after k ticks, gate held high, counting from the setup
  function automatic logic exp_out(input int m, input int n, input int k);
    case (m)
      0: return k >= n;
      1: return (k < 1) || (k > n);
      2: return (k % n) != (n - 1);
      3: return (k % n) < ((n + 1) / 2);
      4: return k != (n - 1);
      default: return k != n;
    endcase
  endfunction

  function automatic string req_of(input int raw, input int b);
    if (raw >= 6) return "R12";
    if (b != 0) return "R9";
    case (raw)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(1'b1, "R1", "after reset");
    gate = 1'b1;
    steps(3);
    gate = 1'b0;
    steps(2);
    chk(1'b1, "R1", "ticks before any write");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int raw;
      int m;
      int b;
      int n;
      int kmax;
      raw  = int'(VEC[v][39:36]);
      b    = int'(VEC[v][35:32]);
      n    = int'(VEC[v][31:16]);
      kmax = int'(VEC[v][15:0]);
      m    = (raw >= 6) ? raw - 4 : raw;
      setup(3'(raw), b[0], (b != 0) ? to_bcd(n) : W'(n), (m == 1) || (m == 5));
      for (int k = 1; k <= kmax; k++) begin
        step();
        chk(exp_out(m, n, k), req_of(raw, b), $sformatf("vector %0d tick %0d", v, k));
      end
    end

    // R2: control write drives low, gate pause, rewrite
    gate = 1'b1;
    step();
    wr_ctrl(3'd0, 1'b0);
    chk(1'b0, "R2", "mode 0 control write");
    wr_cnt(16'd5);
    steps(2);
    gate = 1'b0;
    for (int i = 0; i < 5; i++) begin step(); chk(1'b0, "R2", "paused by gate"); end
    gate = 1'b1;
    steps(2);
    chk(1'b0, "R2", "one count left");
    step();
    chk(1'b1, "R2", "terminal count");
    steps(4);
    chk(1'b1, "R2", "stays high");
    wr_cnt(16'd2);
    chk(1'b0, "R2", "new count drives low");
    steps(2);
    chk(1'b1, "R2", "second terminal count");

    // R3: retrigger lengthens the one-shot
    setup(3'd1, 1'b0, 16'd4, 1'b1);
    steps(3);
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    chk(1'b0, "R3", "retrigger tick");
    for (int i = 1; i <= 3; i++) begin step(); chk(1'b0, "R3", "retriggered pulse"); end
    step();
    chk(1'b1, "R3", "retriggered pulse end");

    // R6: gate force and resync in mode 3
    setup(3'd3, 1'b0, 16'd8, 1'b0);
    steps(5);
    chk(1'b0, "R6", "mode 3 low phase");
    gate = 1'b0;
    @(negedge clk);
    chk(1'b1, "R6", "gate drop forces high");
    for (int i = 0; i < 3; i++) begin step(); chk(1'b1, "R6", "gate low holds high"); end
    gate = 1'b1;
    step();
    chk(1'b1, "R6", "resync tick");
    for (int j = 1; j <= 9; j++) begin
      step();
      chk((j % 8) < 4, "R6", $sformatf("after resync tick %0d", j));
    end
    setup(3'd2, 1'b0, 16'd4, 1'b0);
    steps(3);
    chk(1'b0, "R6", "mode 2 strobe");
    gate = 1'b0;
    @(negedge clk);
    chk(1'b1, "R6", "mode 2 gate drop");

    // R7: software strobe, pause, one shot only, restart by count write
    setup(3'd4, 1'b0, 16'd5, 1'b0);
    steps(2);
    gate = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); chk(1'b1, "R7", "paused"); end
    gate = 1'b1;
    step();
    chk(1'b1, "R7", "before strobe");
    step();
    chk(1'b0, "R7", "strobe");
    gate = 1'b0;
    @(negedge clk);
    chk(1'b0, "R7", "gate low leaves output");
    gate = 1'b1;
    step();
    chk(1'b1, "R7", "strobe end");
    steps(8);
    chk(1'b1, "R7", "no second strobe");
    wr_cnt(16'd3);
    step();
    chk(1'b1, "R7", "restart first tick");
    step();
    chk(1'b0, "R7", "restart strobe");

    // R8: retrigger during gate-started strobe
    setup(3'd5, 1'b0, 16'd5, 1'b1);
    steps(3);
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    chk(1'b1, "R8", "retrigger tick");
    for (int j = 1; j <= 5; j++) begin
      step();
      chk(j != 4, "R8", $sformatf("after retrigger tick %0d", j));
    end

    // R11: gate pulse between ticks is not an edge
    setup(3'd5, 1'b0, 16'd4, 1'b0);
    gate = 1'b0;
    @(negedge clk);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin step(); chk(1'b1, "R11", "no sampled edge"); end
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    for (int j = 2; j <= 5; j++) begin
      step();
      chk(j != 4, "R11", $sformatf("real edge tick %0d", j));
    end
    setup(3'd2, 1'b0, 16'd5, 1'b0);
    steps(2);
    repeat (20) @(negedge clk);
    steps(2);
    chk(1'b0, "R11", "idle cycles do not count");

    // R10: zero count means maximum
    setup(3'd0, 1'b0, 16'd0, 1'b0);
    steps(65535);
    chk(1'b0, "R10", "binary zero one tick short");
    step();
    chk(1'b1, "R10", "binary zero full range");
    setup(3'd0, 1'b1, 16'd0, 1'b0);
    steps(9999);
    chk(1'b0, "R10", "decimal zero one tick short");
    step();
    chk(1'b1, "R10", "decimal zero full range");

    summary();
  end

endmodule